// File: doc/BRIEF.md
# Serial NAND Command Responder

This block is the device side of a serial NAND flash command layer. A separate shifter delivers whole received bytes, one per `byte_valid` strobe, and signals the release of chip select with a one-cycle `cs_end` pulse. For each byte presented, the block answers with one byte on `tx_byte` in the same cycle. The shifter sends that byte back on the following byte slot.

A small state machine decodes the first byte of every chip-select session as an opcode. The supported operations are:

- reset;
- identification readout;
- feature-register read and write, with the register selected by an address byte;
- a two-stage page read.

In the page read, a page-load command names a page, and the page is copied from an internal storage array into a page cache when chip select is released. A later cache-read command names a starting column, returns one dummy byte, and then streams cache bytes.

The storage array holds `PAGE_COUNT` pages of `PAGE_BYTES` bytes. A preload port fills it for test. Storage and cache hold the erased value 0xFF after reset.

Top module: `nand_cmd_responder`

## Requirements
- R1: After `rst_n` is released, all four feature registers read 0x00 and every page-cache byte reads 0xFF.
- R2: `tx_byte` is 0x00 in any cycle without `byte_valid`. It is also 0x00 for every opcode byte and every address, column and dummy byte.
- R3: Opcode 0x9F answers the three following bytes with 0x00, 0xEF and 0xBC in that order, and answers any later byte of the session with 0x00.
- R4: Opcode 0x0F takes one address byte and answers the next byte with the value of the selected feature register. The registers sit at 0xA0, 0xB0, 0xC0 and 0xD0, and any other address reads 0x00.
- R5: Opcode 0x1F takes one address byte and writes the next byte into the selected register. A write to an address outside 0xA0/0xB0/0xC0/0xD0 changes nothing, and bytes after the data byte change nothing.
- R6: Opcode 0x13 takes three address bytes, most significant first. Their value modulo `PAGE_COUNT` selects a page, which is copied into the cache on the `cs_end` that closes the session.
- R7: If a 0x13 session closes after any number of address bytes other than three, the cache keeps its previous contents.
- R8: Opcodes 0x03 and 0x0B behave identically. They take two column bytes, most significant first, then answer one dummy byte with 0x00, then answer each further byte with the cache byte at the column, advancing the column by one per byte.
- R9: The starting column is taken modulo `PAGE_BYTES`, and the stream wraps from the last cache byte to byte 0.
- R10: Any other opcode makes the block answer 0x00 to every byte until `cs_end`. The next byte after `cs_end` is decoded as an opcode again.
- R11: Opcode 0xFF clears all feature registers to 0x00 and leaves the block idle, so the next byte of the same session is decoded as an opcode. Cache and storage are kept.
- R12: `cs_end` aborts any operation in progress, so the next byte is decoded as an opcode.
- R13: A preload write with `pl_we` high stores `pl_data` at storage index `pl_addr`, which is page × `PAGE_BYTES` + offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A received byte is presented this cycle |
| rx_byte | input | 8 | Received byte |
| cs_end | input | 1 | One-cycle pulse on chip-select release; takes priority over `byte_valid` |
| tx_byte | output | 8 | Response to the byte presented this cycle |
| pl_we | input | 1 | Storage preload write enable |
| pl_addr | input | log2(PAGE_COUNT)+log2(PAGE_BYTES) | Storage preload byte index |
| pl_data | input | 8 | Storage preload data |

## Verification
Every response is combinational. `tx_byte` is due in the same cycle as its `rx_byte`, so the bench drives each byte just after a falling edge and samples one time unit later, before the rising edge that consumes it.

Register writes, the page load at `cs_end` and preload writes all take effect on that rising edge. Their results are therefore only checked through bytes of a later session.

A check that something is left unchanged reads the affected register or cache bytes back through a fresh get-feature or cache-read session.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

   localparam logic [7:0] OP_RESET      = 8'hFF;
   localparam logic [7:0] OP_READ_ID    = 8'h9F;
   localparam logic [7:0] OP_GET_FEAT   = 8'h0F;
   localparam logic [7:0] OP_SET_FEAT   = 8'h1F;
   localparam logic [7:0] OP_PAGE_LOAD  = 8'h13;
   localparam logic [7:0] OP_CACHE_RD   = 8'h03;
   localparam logic [7:0] OP_CACHE_RD_F = 8'h0B;

   localparam int         FEAT_COUNT = 4;
   localparam logic [7:0] FEAT_BASE  = 8'hA0;
   localparam logic [7:0] FEAT_STEP  = 8'h10;
   localparam logic [7:0] ERASED     = 8'hFF;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ID_OUT,
      ST_GF_ADDR,
      ST_GF_DATA,
      ST_SF_ADDR,
      ST_SF_DATA,
      ST_PG_ADDR,
      ST_CR_COL,
      ST_CR_DUMMY,
      ST_CR_STREAM,
      ST_IGNORE
   } resp_state_e;

   function automatic logic [7:0] feat_addr_of(input int idx);
      return FEAT_BASE + 8'(idx) * FEAT_STEP;
   endfunction

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd1:    return 8'hEF;
         3'd2:    return 8'hBC;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/nand_feature_regs.sv
module nand_feature_regs
   import nand_resp_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    we,
   input  logic [7:0]              addr,
   input  logic [7:0]              wdata,
   output logic [7:0]              rdata,
   output logic [FEAT_COUNT*8-1:0] regs_flat
);

   for (genvar g = 0; g < FEAT_COUNT; g++) begin : g_reg
      localparam logic [7:0] MY_ADDR = feat_addr_of(g);
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                       q <= 8'h00;
         else if (clear)                   q <= 8'h00;
         else if (we && addr == MY_ADDR)   q <= wdata;
      end
      assign regs_flat[g*8 +: 8] = q;
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < FEAT_COUNT; i++) begin
         if (addr == feat_addr_of(i)) rdata = regs_flat[i*8 +: 8];
      end
   end

endmodule

// File: rtl/nand_page_store.sv
module nand_page_store
   import nand_resp_pkg::*;
#(
   parameter int PAGE_BYTES = 16,
   parameter int PAGE_COUNT = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 pl_we,
   input  logic [$clog2(PAGE_COUNT)+$clog2(PAGE_BYTES)-1:0] pl_addr,
   input  logic [7:0]                           pl_data,
   input  logic [$clog2(PAGE_COUNT)-1:0]        rd_page,
   output logic [PAGE_BYTES*8-1:0]              rd_bytes
);

   localparam int CW    = $clog2(PAGE_BYTES);
   localparam int DEPTH = PAGE_BYTES * PAGE_COUNT;

   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
      end else if (pl_we) begin
         mem_q[pl_addr] <= pl_data;
      end
   end

   for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_rd
      assign rd_bytes[b*8 +: 8] = mem_q[{rd_page, CW'(b)}];
   end

endmodule

// File: rtl/nand_page_cache.sv
module nand_page_cache
   import nand_resp_pkg::*;
#(
   parameter int PAGE_BYTES = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [PAGE_BYTES*8-1:0]       load_bytes,
   input  logic [$clog2(PAGE_BYTES)-1:0] rd_col,
   output logic [7:0]                    rd_byte,
   output logic [PAGE_BYTES*8-1:0]       cache_flat
);

   logic [7:0] c_q [PAGE_BYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE_BYTES; i++) c_q[i] <= ERASED;
      end else if (load) begin
         for (int i = 0; i < PAGE_BYTES; i++) c_q[i] <= load_bytes[i*8 +: 8];
      end
   end

   assign rd_byte = c_q[rd_col];

   for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_flat
      assign cache_flat[b*8 +: 8] = c_q[b];
   end

endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
   import nand_resp_pkg::*;
#(
   parameter int PW = 3,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byte_valid,
   input  logic [7:0]    rx_byte,
   input  logic          cs_end,
   input  logic [7:0]    feat_rdata,
   input  logic [7:0]    cache_byte,
   output logic [7:0]    tx_byte,
   output logic          feat_we,
   output logic          feat_clear,
   output logic [7:0]    feat_addr,
   output logic [CW-1:0] cache_col,
   output logic          load_en,
   output logic [PW-1:0] load_page,
   output resp_state_e   state_o
);

   resp_state_e   state_q;
   logic [2:0]    cnt_q;
   logic [7:0]    addr_q;
   logic [PW-1:0] pg_q;
   logic [CW-1:0] col_q;
   logic          take;

   assign take = byte_valid & ~cs_end;

   always_comb begin
      tx_byte = 8'h00;
      if (take) begin
         case (state_q)
            ST_ID_OUT:    tx_byte = id_byte(cnt_q);
            ST_GF_DATA:   tx_byte = feat_rdata;
            ST_CR_STREAM: tx_byte = cache_byte;
            default:      tx_byte = 8'h00;
         endcase
      end
   end

   assign feat_we    = take && state_q == ST_SF_DATA;
   assign feat_clear = take && state_q == ST_IDLE && rx_byte == OP_RESET;
   assign feat_addr  = addr_q;
   assign cache_col  = col_q;
   assign load_en    = cs_end && state_q == ST_PG_ADDR && cnt_q == 3'd3;
   assign load_page  = pg_q;
   assign state_o    = state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= 3'd0;
         addr_q  <= 8'h00;
         pg_q    <= '0;
         col_q   <= '0;
      end else if (cs_end) begin
         state_q <= ST_IDLE;
         cnt_q   <= 3'd0;
      end else if (byte_valid) begin
         case (state_q)
            ST_IDLE: begin
               cnt_q <= 3'd0;
               case (rx_byte)
                  OP_RESET:     state_q <= ST_IDLE;
                  OP_READ_ID:   state_q <= ST_ID_OUT;
                  OP_GET_FEAT:  state_q <= ST_GF_ADDR;
                  OP_SET_FEAT:  state_q <= ST_SF_ADDR;
                  OP_PAGE_LOAD: begin
                     state_q <= ST_PG_ADDR;
                     pg_q    <= '0;
                  end
                  OP_CACHE_RD, OP_CACHE_RD_F: begin
                     state_q <= ST_CR_COL;
                     col_q   <= '0;
                  end
                  default:      state_q <= ST_IGNORE;
               endcase
            end
            ST_ID_OUT: if (cnt_q != 3'd3) cnt_q <= cnt_q + 3'd1;
            ST_GF_ADDR: begin
               addr_q  <= rx_byte;
               state_q <= ST_GF_DATA;
            end
            ST_GF_DATA: state_q <= ST_IGNORE;
            ST_SF_ADDR: begin
               addr_q  <= rx_byte;
               state_q <= ST_SF_DATA;
            end
            ST_SF_DATA: state_q <= ST_IGNORE;
            ST_PG_ADDR: begin
               pg_q <= PW'({pg_q, rx_byte});
               if (cnt_q != 3'd4) cnt_q <= cnt_q + 3'd1;
            end
            ST_CR_COL: begin
               col_q <= CW'({col_q, rx_byte});
               cnt_q <= cnt_q + 3'd1;
               if (cnt_q == 3'd1) state_q <= ST_CR_DUMMY;
            end
            ST_CR_DUMMY:  state_q <= ST_CR_STREAM;
            ST_CR_STREAM: col_q   <= col_q + CW'(1);
            default:      state_q <= ST_IGNORE;
         endcase
      end
   end

endmodule

// File: rtl/nand_cmd_responder.sv
module nand_cmd_responder
   import nand_resp_pkg::*;
#(
   parameter int PAGE_BYTES = 16,
   parameter int PAGE_COUNT = 8
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             byte_valid,
   input  logic [7:0]                                       rx_byte,
   input  logic                                             cs_end,
   output logic [7:0]                                       tx_byte,
   input  logic                                             pl_we,
   input  logic [$clog2(PAGE_COUNT)+$clog2(PAGE_BYTES)-1:0] pl_addr,
   input  logic [7:0]                                       pl_data
);

   localparam int PW = $clog2(PAGE_COUNT);
   localparam int CW = $clog2(PAGE_BYTES);

   initial begin
      if (PAGE_BYTES < 2 || (1 << CW) != PAGE_BYTES)
         $fatal(1, "PAGE_BYTES must be a power of two of at least 2");
      if (PAGE_COUNT < 2 || (1 << PW) != PAGE_COUNT)
         $fatal(1, "PAGE_COUNT must be a power of two of at least 2");
   end

   logic                    feat_we, feat_clear, cache_load;
   logic [7:0]              feat_addr, feat_rdata, cache_byte;
   logic [CW-1:0]           cache_col;
   logic [PW-1:0]           load_page;
   logic [PAGE_BYTES*8-1:0] page_bytes, cache_flat;
   logic [FEAT_COUNT*8-1:0] feat_flat;
   resp_state_e             fsm_state;

   nand_cmd_fsm #(.PW(PW), .CW(CW)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .rx_byte    (rx_byte),
      .cs_end     (cs_end),
      .feat_rdata (feat_rdata),
      .cache_byte (cache_byte),
      .tx_byte    (tx_byte),
      .feat_we    (feat_we),
      .feat_clear (feat_clear),
      .feat_addr  (feat_addr),
      .cache_col  (cache_col),
      .load_en    (cache_load),
      .load_page  (load_page),
      .state_o    (fsm_state)
   );

   nand_feature_regs u_feat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (feat_clear),
      .we        (feat_we),
      .addr      (feat_addr),
      .wdata     (rx_byte),
      .rdata     (feat_rdata),
      .regs_flat (feat_flat)
   );

   nand_page_store #(.PAGE_BYTES(PAGE_BYTES), .PAGE_COUNT(PAGE_COUNT)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .pl_we    (pl_we),
      .pl_addr  (pl_addr),
      .pl_data  (pl_data),
      .rd_page  (load_page),
      .rd_bytes (page_bytes)
   );

   nand_page_cache #(.PAGE_BYTES(PAGE_BYTES)) u_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cache_load),
      .load_bytes (page_bytes),
      .rd_col     (cache_col),
      .rd_byte    (cache_byte),
      .cache_flat (cache_flat)
   );

endmodule

// File: rtl/nand_resp_checker.sv
module nand_resp_checker
   import nand_resp_pkg::*;
#(
   parameter int PAGE_BYTES = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    byte_valid,
   input logic                    cs_end,
   input logic [7:0]              rx_byte,
   input logic [7:0]              tx_byte,
   input resp_state_e             fsm_state,
   input logic [FEAT_COUNT*8-1:0] feat_flat,
   input logic                    cache_load,
   input logic [PAGE_BYTES*8-1:0] cache_flat
);

   p_quiet_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |-> tx_byte == 8'h00);

   p_cs_to_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cs_end |=> fsm_state == ST_IDLE);

   p_ignore_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_IGNORE && byte_valid && !cs_end)
         |=> fsm_state == ST_IGNORE);

   p_ignore_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_IGNORE && byte_valid) |-> tx_byte == 8'h00);

   p_reset_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !cs_end && fsm_state == ST_IDLE && rx_byte == OP_RESET)
         |=> (feat_flat == '0 && fsm_state == ST_IDLE));

   p_cache_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cache_load |=> $stable(cache_flat));

endmodule

bind nand_cmd_responder nand_resp_checker #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_valid (byte_valid),
   .cs_end     (cs_end),
   .rx_byte    (rx_byte),
   .tx_byte    (tx_byte),
   .fsm_state  (fsm_state),
   .feat_flat  (feat_flat),
   .cache_load (cache_load),
   .cache_flat (cache_flat)
);

// File: tb/test_nand_cmd_responder.sv
module test_nand_cmd_responder;

   localparam int CLK_PERIOD = 10;
   localparam int PB = 16;
   localparam int PC = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       cs_end = 1'b0;
   logic [7:0] tx_byte;
   logic       pl_we = 1'b0;
   logic [6:0] pl_addr = '0;
   logic [7:0] pl_data = 8'h00;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_cmd_responder #(.PAGE_BYTES(PB), .PAGE_COUNT(PC)) i_nand_cmd_responder (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_byte(rx_byte),
      .cs_end(cs_end), .tx_byte(tx_byte), .pl_we(pl_we), .pl_addr(pl_addr),
      .pl_data(pl_data));

   function automatic logic [7:0] pat(input int p, input int i);
      return 8'((p * PB + i) * 7 + 3);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] b, output logic [7:0] r);
      @(negedge clk);
      byte_valid = 1'b1;
      rx_byte    = b;
      #1 r = tx_byte;
      @(posedge clk);
      #1 byte_valid = 1'b0;
   endtask

   task automatic xchk(input logic [7:0] b, input logic [7:0] exp, input string req);
      logic [7:0] r;
      xfer(b, r);
      chk(req, r, exp);
   endtask

   task automatic end_cs;
      @(negedge clk);
      cs_end = 1'b1;
      @(posedge clk);
      #1 cs_end = 1'b0;
   endtask

   task automatic get_feat(input logic [7:0] a, input logic [7:0] exp, input string req);
      xchk(8'h0F, 8'h00, "R2 get opcode");
      xchk(a, 8'h00, "R2 get address");
      xchk(8'h00, exp, req);
      xchk(8'h00, 8'h00, "R4 byte after value");
      end_cs();
   endtask

   task automatic set_feat(input logic [7:0] a, input logic [7:0] d);
      xchk(8'h1F, 8'h00, "R2 set opcode");
      xchk(a, 8'h00, "R2 set address");
      xchk(d, 8'h00, "R5 set data answer");
      end_cs();
   endtask

   task automatic page_load(input logic [7:0] b2, input logic [7:0] b1, input logic [7:0] b0);
      xchk(8'h13, 8'h00, "R2 page opcode");
      xchk(b2, 8'h00, "R6 address byte");
      xchk(b1, 8'h00, "R6 address byte");
      xchk(b0, 8'h00, "R6 address byte");
      end_cs();
   endtask

   // page < 0 means erased cache contents
   task automatic read_cache(input logic [7:0] op, input logic [15:0] col, input int n,
                             input int page, input string req);
      xchk(op, 8'h00, "R2 cache opcode");
      xchk(col[15:8], 8'h00, "R2 column high");
      xchk(col[7:0], 8'h00, "R2 column low");
      xchk(8'h00, 8'h00, "R8 dummy byte");
      for (int k = 0; k < n; k++) begin
         int idx = (int'(col) + k) % PB;
         xchk(8'h00, (page < 0) ? 8'hFF : pat(page, idx), req);
      end
      end_cs();
   endtask

   task automatic t_reset_state;
      chk("R2 idle no strobe", tx_byte, 8'h00);
      get_feat(8'hA0, 8'h00, "R1 lock reg after reset");
      get_feat(8'hB0, 8'h00, "R1 config reg after reset");
      get_feat(8'hC0, 8'h00, "R1 status reg after reset");
      get_feat(8'hD0, 8'h00, "R1 die reg after reset");
      read_cache(8'h03, 16'h0000, 4, -1, "R1 cache erased");
   endtask

   task automatic t_read_id;
      xchk(8'h9F, 8'h00, "R2 id opcode");
      xchk(8'h55, 8'h00, "R3 id byte 0");
      xchk(8'h55, 8'hEF, "R3 id byte 1");
      xchk(8'h55, 8'hBC, "R3 id byte 2");
      xchk(8'h55, 8'h00, "R3 id past end");
      end_cs();
   endtask

   task automatic t_features;
      set_feat(8'hB0, 8'h5A);
      get_feat(8'hB0, 8'h5A, "R4 read config");
      set_feat(8'hA0, 8'h11);
      set_feat(8'hC0, 8'h22);
      set_feat(8'hD0, 8'h33);
      set_feat(8'hE5, 8'h99);
      get_feat(8'hA0, 8'h11, "R5 lock reg kept");
      get_feat(8'hC0, 8'h22, "R5 status written");
      get_feat(8'hD0, 8'h33, "R5 die written");
      get_feat(8'hE5, 8'h00, "R4 unknown address reads zero");
      xchk(8'h1F, 8'h00, "R2 set opcode");
      xchk(8'hC0, 8'h00, "R2 set address");
      xchk(8'h44, 8'h00, "R5 data");
      xchk(8'h99, 8'h00, "R5 trailing byte");
      end_cs();
      get_feat(8'hC0, 8'h44, "R5 trailing byte ignored");
   endtask

   task automatic t_page_read;
      for (int p = 0; p < PC; p++)
         for (int i = 0; i < PB; i++) begin
            @(negedge clk);
            pl_we = 1'b1; pl_addr = 7'(p * PB + i); pl_data = pat(p, i);
            @(posedge clk);
            #1 pl_we = 1'b0;
         end
      page_load(8'h00, 8'h00, 8'h03);
      read_cache(8'h03, 16'h0005, 3, 3, "R6 R13 page 3 stream");
      page_load(8'h00, 8'h01, 8'h0A);
      read_cache(8'h0B, 16'h0000, 4, 2, "R8 fast opcode page 266 mod 8");
   endtask

   task automatic t_bad_count;
      xchk(8'h13, 8'h00, "R2 page opcode");
      xchk(8'h00, 8'h00, "R2 addr");
      xchk(8'h05, 8'h00, "R2 addr");
      end_cs();
      read_cache(8'h03, 16'h0000, 3, 2, "R7 two bytes no load");
      xchk(8'h13, 8'h00, "R2 page opcode");
      for (int k = 0; k < 4; k++) xchk(8'h05, 8'h00, "R2 addr");
      end_cs();
      read_cache(8'h03, 16'h0008, 2, 2, "R7 four bytes no load");
   endtask

   task automatic t_wrap;
      read_cache(8'h03, 16'h000E, 4, 2, "R9 wrap past last byte");
      read_cache(8'h0B, 16'h0013, 2, 2, "R9 column modulo page");
   endtask

   task automatic t_unknown;
      xchk(8'h42, 8'h00, "R10 unknown opcode");
      xchk(8'h9F, 8'h00, "R10 ignored byte");
      xchk(8'h00, 8'h00, "R10 ignored byte");
      xchk(8'h00, 8'h00, "R10 ignored byte");
      end_cs();
      xchk(8'h9F, 8'h00, "R10 fresh opcode");
      xchk(8'h00, 8'h00, "R10 id byte 0");
      xchk(8'h00, 8'hEF, "R10 id byte 1");
      end_cs();
   endtask

   task automatic t_reset_cmd;
      set_feat(8'hA0, 8'h77);
      xchk(8'hFF, 8'h00, "R11 reset opcode");
      xchk(8'h0F, 8'h00, "R11 next opcode");
      xchk(8'hA0, 8'h00, "R11 address");
      xchk(8'h00, 8'h00, "R11 lock cleared");
      end_cs();
      get_feat(8'hC0, 8'h00, "R11 status cleared");
      read_cache(8'h03, 16'h0001, 2, 2, "R11 cache kept");
   endtask

   task automatic t_cs_abort;
      xchk(8'h9F, 8'h00, "R2 id opcode");
      xchk(8'h00, 8'h00, "R12 id byte 0");
      xchk(8'h00, 8'hEF, "R12 id byte 1");
      end_cs();
      xchk(8'h9F, 8'h00, "R12 restart opcode");
      xchk(8'h00, 8'h00, "R12 id restarts at 0");
      end_cs();
      xchk(8'h1F, 8'h00, "R2 set opcode");
      xchk(8'hB0, 8'h00, "R2 set address");
      end_cs();
      xchk(8'h66, 8'h00, "R12 byte is opcode not data");
      end_cs();
      get_feat(8'hB0, 8'h00, "R12 aborted write left config");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_read_id();
      t_features();
      t_page_read();
      t_bad_count();
      t_wrap();
      t_unknown();
      t_reset_cmd();
      t_cs_abort();
      repeat (2) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule